// File: doc/BRIEF.md
# Magnitude Threshold Detector with Persistence Filter

This block watches a stream of signed conversion results and raises a one-cycle interrupt when their magnitude is large enough. Each sample arrives with a valid strobe. The block takes the magnitude of the sample and compares it with an unsigned threshold. A two-bit mode then chooses what a hit means. The detector can be switched off. It can flag every single hit. It can also require a programmed number of hits before it fires.

In the two counting modes a miss affects the hit counter. In the restart policy any miss drops the counter back to zero, so the hits must come in an unbroken run. In the decay policy a miss only steps the counter down by one, with a floor at zero. Isolated low samples then only slow the detection and do not cancel it. The live counter value is brought out on a port so that it can be read.

Top module: `mag_persist_cmp`

## Requirements
- R1: With mode 2'b00 (off), a valid sample never produces an interrupt, and the hit counter reads 0 after it.
- R2: With mode 2'b01 (instant), a valid sample whose magnitude is greater than or equal to the threshold drives `irq_pulse` high in the cycle after the strobe edge. A sample below the threshold leaves it low. The counter stays 0.
- R3: The magnitude is taken from the sample as 16-bit two's complement. The most negative code 0x8000 gives 0x7FFF. The threshold is an unsigned 15-bit magnitude.
- R4: With mode 2'b10 (restart), a hit adds one to the counter. A valid sample below the threshold sets the counter to 0.
- R5: With mode 2'b11 (decay), a hit adds one to the counter. A valid sample below the threshold takes one off the counter, and the counter does not go below 0.
- R6: In modes 2'b10 and 2'b11, the hit that brings the count up to the target raises `irq_pulse` for exactly one cycle. On that same edge the counter goes back to 0.
- R7: A target of 0 acts as a target of 1.
- R8: When a valid sample arrives with a mode that differs from the mode of the previous valid sample, the counter is cleared first. That sample is then applied under the new mode.
- R9: While `smp_valid` is low, the counter holds its value and `irq_pulse` stays low.
- R10: After reset `irq_pulse` is 0, the counter is 0, and the last mode seen is taken to be off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe: a new sample is present this cycle |
| smp_data | input | SAMPLE_W | Signed two's-complement sample |
| thresh | input | SAMPLE_W-1 | Unsigned magnitude threshold |
| hit_target | input | CNT_W | Hits needed to fire in the counting modes (0 acts as 1) |
| mode | input | 2 | 00 off, 01 instant, 10 restart, 11 decay |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| hit_count | output | CNT_W | Live persistence counter |

## Verification
The assertions are checked on every cycle. They cover the following: the counter holds and the interrupt stays quiet without a strobe; off mode stays silent; instant mode follows the compare result; a miss in restart mode clears the counter; a miss in decay mode steps the counter down by exactly one, floored at 0; and a firing always leaves the counter at zero. Some behaviours can only be shown by the bench scenarios, where an arithmetic model checks them on every edge. These are the saturated magnitude of the most negative code, firing at the exact programmed target for every target value including zero, and the clearing of the counter when the mode changes between samples.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

   typedef enum logic [1:0] {
      MC_OFF     = 2'b00,
      MC_INSTANT = 2'b01,
      MC_RESTART = 2'b10,
      MC_DECAY   = 2'b11
   } mc_mode_e;

endpackage

// File: rtl/mcp_magnitude.sv
module mcp_magnitude #(
   parameter int SAMPLE_W = 16
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W-2:0] thresh,
   output logic [SAMPLE_W-2:0] mag,
   output logic                at_or_above
);
   localparam int MAG_W = SAMPLE_W - 1;
   localparam logic [MAG_W-1:0] MAG_MAX = '1;

   logic               is_neg;
   logic               is_most_neg;
   logic [SAMPLE_W-1:0] negated;

   always_comb begin
      is_neg      = sample[SAMPLE_W-1];
      is_most_neg = is_neg && (sample[MAG_W-1:0] == '0);
      negated     = '0 - sample;
      if (!is_neg)
         mag = sample[MAG_W-1:0];
      else if (is_most_neg)
         mag = MAG_MAX;
      else
         mag = negated[MAG_W-1:0];
      at_or_above = (mag >= thresh);
   end

endmodule

// File: rtl/mcp_persist_ctr.sv
module mcp_persist_ctr
   import mag_cmp_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             hit,
   input  mc_mode_e         mode,
   input  logic [CNT_W-1:0] target,
   output logic             irq,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W:0] ONE_W = (CNT_W+1)'(1);

   mc_mode_e         mode_q;
   logic [CNT_W-1:0] count_q;
   logic             irq_q;

   logic [CNT_W-1:0] base;
   logic [CNT_W:0]   bumped;
   logic [CNT_W:0]   tgt_eff;
   logic [CNT_W-1:0] next_count;
   logic             fire;

   always_comb begin
      base    = (mode != mode_q) ? '0 : count_q;
      bumped  = {1'b0, base} + ONE_W;
      tgt_eff = (target == '0) ? ONE_W : {1'b0, target};
      next_count = '0;
      fire       = 1'b0;
      unique case (mode)
         MC_OFF: begin
            next_count = '0;
         end
         MC_INSTANT: begin
            next_count = '0;
            fire       = hit;
         end
         MC_RESTART, MC_DECAY: begin
            if (hit) begin
               if (bumped >= tgt_eff) begin
                  fire       = 1'b1;
                  next_count = '0;
               end else begin
                  next_count = bumped[CNT_W-1:0];
               end
            end else if (mode == MC_RESTART) begin
               next_count = '0;
            end else begin
               next_count = (base == '0) ? '0 : base - CNT_W'(1);
            end
         end
         default: next_count = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MC_OFF;
         count_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= valid && fire;
         if (valid) begin
            mode_q  <= mode;
            count_q <= next_count;
         end
      end
   end

   assign irq   = irq_q;
   assign count = count_q;

   // R9: no strobe, no change
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> ($stable(count_q) && !irq_q));

   // R1: off mode is silent
   a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && mode == MC_OFF) |=> (!irq_q && count_q == '0));

   // R2: instant mode follows the compare
   a_r2_instant_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && mode == MC_INSTANT) |=> (irq_q == $past(hit) && count_q == '0));

   // R4: a miss in restart mode clears the count
   a_r4_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && mode == MC_RESTART && !hit) |=> (count_q == '0 && !irq_q));

   // R5: a miss in decay mode steps down by one, floored at zero
   a_r5_decay_step: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && mode == MC_DECAY && mode_q == MC_DECAY && !hit) |=>
         (count_q == (($past(count_q) == '0) ? '0 : ($past(count_q) - CNT_W'(1)))));

   // R6: a firing restarts the window
   a_r6_fire_restart: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (count_q == '0));

endmodule

// File: rtl/mag_persist_cmp.sv
module mag_persist_cmp
   import mag_cmp_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int CNT_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic [SAMPLE_W-2:0] thresh,
   input  logic [CNT_W-1:0]    hit_target,
   input  logic [1:0]          mode,
   output logic                irq_pulse,
   output logic [CNT_W-1:0]    hit_count
);
   localparam int MAG_W = SAMPLE_W - 1;

   generate
      if (SAMPLE_W < 2) begin : g_bad_sample_w
         $error("mag_persist_cmp: SAMPLE_W must be at least 2");
      end
      if (CNT_W < 1 || CNT_W > 31) begin : g_bad_cnt_w
         $error("mag_persist_cmp: CNT_W must be between 1 and 31");
      end
   endgenerate

   logic [MAG_W-1:0] mag;
   logic             hit;
   mc_mode_e         mode_e;

   assign mode_e = mc_mode_e'(mode);

   mcp_magnitude #(
      .SAMPLE_W(SAMPLE_W)
   ) u_mag (
      .sample      (smp_data),
      .thresh      (thresh),
      .mag         (mag),
      .at_or_above (hit)
   );

   mcp_persist_ctr #(
      .CNT_W(CNT_W)
   ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid  (smp_valid),
      .hit    (hit),
      .mode   (mode_e),
      .target (hit_target),
      .irq    (irq_pulse),
      .count  (hit_count)
   );

   // R10: reset leaves the output quiet on the first edge out of reset
   a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_pulse && hit_count == '0));

endmodule

// File: tb/test_mag_persist_cmp.sv
module test_mag_persist_cmp;
   localparam int SW = 16;
   localparam int CW = 4;
   localparam time HALF = 4ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [SW-1:0] smp_data = '0;
   logic [SW-2:0] thresh = '0;
   logic [CW-1:0] hit_target = '0;
   logic [1:0]    mode = 2'b00;
   logic          irq_pulse;
   logic [CW-1:0] hit_count;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   int m_cnt = 0;
   int m_prev = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #HALF clk = ~clk;

   mag_persist_cmp #(.SAMPLE_W(SW), .CNT_W(CW)) i_mag_persist_cmp (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .thresh(thresh), .hit_target(hit_target), .mode(mode),
      .irq_pulse(irq_pulse), .hit_count(hit_count));

   task automatic check(input string tag, input int got, input int exp, input string what);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   function automatic int mag_of(input logic [SW-1:0] s);
      int v = int'($signed(s));
      if (v < 0) v = -v;
      if (v > 32767) v = 32767;
      return v;
   endfunction

   function automatic logic [15:0] step_lfsr(input logic [15:0] x);
      return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
   endfunction

   // drive at negedge, model, then check at the following negedge
   task automatic apply(input bit v, input logic [SW-1:0] s, input int thr,
                        input int tgt, input int md, input string tag_in);
      int exp_irq = 0;
      int eff;
      int base;
      string tag = tag_in;
      smp_valid  = v;
      smp_data   = s;
      thresh     = (SW-1)'(thr);
      hit_target = CW'(tgt);
      mode       = 2'(md);
      if (v) begin
         bit hit = (mag_of(s) >= thr);
         base = (md != m_prev) ? 0 : m_cnt;
         m_prev = md;
         eff = (tgt == 0) ? 1 : tgt;
         case (md)
            0: m_cnt = 0;
            1: begin m_cnt = 0; exp_irq = hit; end
            default: begin
               if (hit) begin
                  if (base + 1 >= eff) begin exp_irq = 1; m_cnt = 0; end
                  else m_cnt = base + 1;
               end else if (md == 2) m_cnt = 0;
               else m_cnt = (base == 0) ? 0 : base - 1;
            end
         endcase
         if (tag == "") begin
            if (md >= 2 && tgt == 0) tag = "R7";
            else if (md >= 2 && exp_irq == 1) tag = "R6";
            else if (md == 2) tag = "R4";
            else if (md == 3) tag = "R5";
            else if (md == 1) tag = "R2";
            else tag = "R1";
         end
      end else if (tag == "") tag = "R9";
      @(posedge clk);
      @(negedge clk);
      check(tag, int'(irq_pulse), exp_irq, "irq_pulse");
      check(tag, int'(hit_count), m_cnt, "hit_count");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check("R10", int'(irq_pulse), 0, "irq_pulse in reset");
      check("R10", int'(hit_count), 0, "hit_count in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", int'(irq_pulse), 0, "irq_pulse after reset");
      check("R10", int'(hit_count), 0, "hit_count after reset");

      // R1: off mode, threshold 0 so every sample would hit
      for (int i = 0; i < 16; i++) apply(1, SW'(i * 1111), 0, 1, 0, "R1");

      // R2 / R3: instant mode sweep of thresholds and edge samples
      begin
         int thrs[5] = '{0, 1, 100, 32766, 32767};
         int smps[11] = '{0, 1, -1, 99, 100, -100, -101, 32767, -32767, -32768, 32766};
         foreach (thrs[t])
            foreach (smps[k])
               apply(1, SW'(smps[k]), thrs[t], 1, 1,
                     (smps[k] == -32768 || smps[k] == -32767) ? "R3" : "R2");
      end
      apply(1, 16'h8000, 32767, 1, 1, "R3");
      apply(1, 16'h8001, 32767, 1, 1, "R3");
      apply(1, 16'h8002, 32767, 1, 1, "R3");

      // R9: build a count, then idle cycles with loud samples
      apply(1, 16'd2000, 1000, 5, 2, "R4");
      apply(1, 16'd2000, 1000, 5, 2, "R4");
      for (int i = 0; i < 5; i++) apply(0, 16'h7FFF, 1000, 5, 3, "R9");
      apply(1, 16'd2000, 1000, 5, 2, "R4");

      // R8: mode change clears before applying the sample
      apply(1, 16'd2000, 1000, 8, 3, "R8");
      apply(1, 16'd2000, 1000, 8, 3, "R5");
      apply(1, 16'd2000, 1000, 8, 2, "R8");
      apply(1, 16'd10,   1000, 8, 3, "R8");
      apply(1, 16'd2000, 1000, 8, 1, "R8");
      apply(1, 16'd2000, 1000, 8, 2, "R8");

      // R4 .. R7: every target in both counting modes, pseudo-random hits and gaps
      for (int md = 2; md <= 3; md++)
         for (int tgt = 0; tgt < 16; tgt++)
            for (int n = 0; n < 48; n++) begin
               int r;
               logic [SW-1:0] s;
               bit v;
               lfsr = step_lfsr(lfsr);
               r = int'(lfsr);
               v = (r[2:0] != 3'd0);
               if (r[5:3] != 3'd0) s = SW'(1000 + (r >> 6));
               else s = SW'((r >> 6) % 1000);
               if (r[15]) s = SW'(-int'($signed(s)));
               apply(v, s, 1000, tgt, md, "");
            end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule